// File: doc/BRIEF.md
# Per-Thread Interrupt Presenter Context

The block keeps the interrupt-management context of a small group of hardware threads. There are four threads at the default setting. Each thread has an OS ring, a pool ring and a physical ring. It also holds a pair of fields that locate that thread's 256-byte reporting area in memory. A delivery request names a thread and a priority. If the priority is more favoured than the thread's current processor priority, the interrupt is presented by raising the notification status byte of the physical ring.

Software reaches the context through a single request port. A request names an operation, a thread and a 32-bit word index into that thread's 64-byte context space. The operations are: a plain word read, a plain word write, an acknowledge read, a write of the current-priority byte, and a pull. An acknowledge read returns the notification status together with the new current priority in one access, and commits both changes in the same cycle.

A pull takes a snapshot of selected context words and clears the valid bits of all three rings. It then streams the snapshot as five big-endian writes into the second 128-byte line of the thread's reporting area.

Top module: `tctx_presenter`

## Requirements
- R1: After reset, the physical word 0 of every thread reads 0x00FF0000, with status 0x00 in bits 31:24 and current priority 0xFF in bits 23:16. Every other mapped word reads 0. `rd_valid` and `mem_wr_valid` are low.
- R2: `req_op` encodings are 0 read, 1 write, 2 acknowledge, 3 current-priority write and 4 pull. Word indices are 1 line-upper field (28 bits), 2 line-lower field (24 bits), 4 OS word 0, 6 OS word 2, 10 pool word 2, 12 physical word 0 and 14 physical word 2. A read or acknowledge answers with `rd_valid` and `rd_data` in the cycle after the request. Any other operation leaves `rd_valid` low. A write to an unmapped index is ignored, and a read of one returns 0. A write to physical word 0 changes only bits 15:0.
- R3: A delivery is presented when its priority is numerically below the thread's current priority and, if one is already pending, below the pending priority. Presenting sets status 0x80 and keeps the current priority. Any other delivery is ignored.
- R4: An acknowledge read with status nonzero returns status in `rd_data[15:8]` and the pending priority in `rd_data[7:0]`, with bits 31:16 zero. The current priority becomes the pending priority and the status becomes 0x00.
- R5: An acknowledge read with status 0x00 returns 0x00 and the unchanged current priority, and modifies no state.
- R6: A current-priority write loads `req_wdata[7:0]`. If a pending priority is greater than or equal to the new value, the status is cleared.
- R7: An accepted pull produces exactly five writes, one per cycle, starting the cycle after the request. In order they are: OS word 0 at +0x90, OS word 2 at +0x98, pool word 2 at +0xA8 and physical word 0 at +0xB0, each with byte enables 4'b1111, and then the physical word-2 top byte at +0xB8 as `mem_wr_data[31:24]` with enables 4'b1000. All values are taken as they stood in the request cycle. Bits 31:24 of the data go to the lowest byte address.
- R8: The reporting-area base is (line-upper field << 32) | (line-lower field << 8).
- R9: A pull clears bit 31, the valid bit, of OS word 2, pool word 2 and physical word 2 of the pulled thread. It leaves all other bits and other threads unchanged.
- R10: A pull requested while a pull stream is still being written is ignored: no further writes occur and nothing is cleared.
- R11: When a port operation and a delivery address the same thread in one cycle, the port operation takes effect first. The delivery is then judged against the resulting current priority and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery request strobe |
| dlv_thread | input | TID_W (2) | Target thread of delivery |
| dlv_prio | input | 8 | Delivery priority, 0 most favoured |
| req_valid | input | 1 | Register port request strobe |
| req_op | input | 3 | Operation code |
| req_thread | input | TID_W (2) | Thread addressed |
| req_word | input | 4 | Word index in the 64-byte context space |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read or acknowledge answer valid |
| rd_data | output | 32 | Read or acknowledge answer |
| mem_wr_valid | output | 1 | Reporting-memory write strobe |
| mem_wr_addr | output | 60 | Reporting-memory byte address |
| mem_wr_data | output | 32 | Write data, big-endian |
| mem_wr_be | output | 4 | Byte enables, bit 3 for the lowest address |

## Verification
A delivery and a port operation can land on the same thread in the same clock cycle. The port operation can be an acknowledge or a current-priority write. The bench drives both strobes on one falling edge. In one case an acknowledge retires priority 5 while priority 3 arrives. In the other, the current priority drops to 2 while priority 3 arrives. The later reads and acknowledges must show that the new delivery was judged against the post-operation priority: it is kept in the first case and dropped in the second. A pull requested in the middle of an active stream is also checked, at the write port and through later reads of the other thread's valid bit.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
    localparam int WORD_W      = 32;
    localparam int PRIO_W      = 8;
    localparam int HI_W        = 28;
    localparam int LO_W        = 24;
    localparam int LINE_ADDR_W = HI_W + 32;
    localparam int IDX_W       = 4;
    localparam int NUM_BEATS   = 5;
    localparam int BEAT_W      = $clog2(NUM_BEATS + 1);

    localparam logic [PRIO_W-1:0] NSR_PHYS  = 8'h80;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = 8'hFF;
    localparam logic [7:0]        ODD_LINE  = 8'h80;

    localparam logic [IDX_W-1:0] W_LHI = 4'd1;
    localparam logic [IDX_W-1:0] W_LLO = 4'd2;
    localparam logic [IDX_W-1:0] W_OS0 = 4'd4;
    localparam logic [IDX_W-1:0] W_OS2 = 4'd6;
    localparam logic [IDX_W-1:0] W_PL2 = 4'd10;
    localparam logic [IDX_W-1:0] W_PH0 = 4'd12;
    localparam logic [IDX_W-1:0] W_PH2 = 4'd14;

    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_ACK  = 3'd2,
        OP_CPPR = 3'd3,
        OP_PULL = 3'd4
    } op_e;

    typedef struct packed {
        logic [WORD_W-1:0] os_w0;
        logic [WORD_W-1:0] os_w2;
        logic [WORD_W-1:0] pool_w2;
        logic [WORD_W-1:0] phys_w2;
        logic [PRIO_W-1:0] nsr;
        logic [PRIO_W-1:0] cppr;
        logic [PRIO_W-1:0] pend;
        logic [15:0]       phys_lo;
        logic [HI_W-1:0]   line_hi;
        logic [LO_W-1:0]   line_lo;
    } ctx_t;

    typedef struct packed {
        logic [LINE_ADDR_W-1:0] base;
        logic [WORD_W-1:0]      os_w0;
        logic [WORD_W-1:0]      os_w2;
        logic [WORD_W-1:0]      pool_w2;
        logic [WORD_W-1:0]      phys_w0;
        logic [7:0]             phys_b;
    } snap_t;
endpackage

// File: rtl/tctx_thread.sv
module tctx_thread
    import tctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  op_e               op,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pull_go,
    input  logic              dlv_hit,
    input  logic [PRIO_W-1:0] dlv_prio,
    output logic [WORD_W-1:0] rd_word,
    output logic [15:0]       ack_word,
    output snap_t             snap
);
    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (sel) begin
            case (op)
                OP_WR: begin
                    case (word_idx)
                        W_LHI:   ctx_d.line_hi = wdata[HI_W-1:0];
                        W_LLO:   ctx_d.line_lo = wdata[LO_W-1:0];
                        W_OS0:   ctx_d.os_w0   = wdata;
                        W_OS2:   ctx_d.os_w2   = wdata;
                        W_PL2:   ctx_d.pool_w2 = wdata;
                        W_PH0:   ctx_d.phys_lo = wdata[15:0];
                        W_PH2:   ctx_d.phys_w2 = wdata;
                        default: ;
                    endcase
                end
                OP_ACK: begin
                    if (ctx_q.nsr != '0) begin
                        ctx_d.cppr = ctx_q.pend;
                        ctx_d.nsr  = '0;
                        ctx_d.pend = PRIO_IDLE;
                    end
                end
                OP_CPPR: begin
                    ctx_d.cppr = wdata[PRIO_W-1:0];
                    if (ctx_q.nsr != '0 && ctx_q.pend >= wdata[PRIO_W-1:0]) begin
                        ctx_d.nsr  = '0;
                        ctx_d.pend = PRIO_IDLE;
                    end
                end
                default: ;
            endcase
        end
        if (pull_go) begin
            ctx_d.os_w2[WORD_W-1]   = 1'b0;
            ctx_d.pool_w2[WORD_W-1] = 1'b0;
            ctx_d.phys_w2[WORD_W-1] = 1'b0;
        end
        // delivery sees the state left by the port operation
        if (dlv_hit && dlv_prio < ctx_d.cppr &&
            (ctx_d.nsr == '0 || dlv_prio < ctx_d.pend)) begin
            ctx_d.nsr  = NSR_PHYS;
            ctx_d.pend = dlv_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ctx_q.cppr <= PRIO_IDLE;
            ctx_q.pend <= PRIO_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        case (word_idx)
            W_LHI:   rd_word = {{(WORD_W-HI_W){1'b0}}, ctx_q.line_hi};
            W_LLO:   rd_word = {{(WORD_W-LO_W){1'b0}}, ctx_q.line_lo};
            W_OS0:   rd_word = ctx_q.os_w0;
            W_OS2:   rd_word = ctx_q.os_w2;
            W_PL2:   rd_word = ctx_q.pool_w2;
            W_PH0:   rd_word = {ctx_q.nsr, ctx_q.cppr, ctx_q.phys_lo};
            W_PH2:   rd_word = ctx_q.phys_w2;
            default: rd_word = '0;
        endcase
    end

    assign ack_word = (ctx_q.nsr != '0) ? {ctx_q.nsr, ctx_q.pend}
                                        : {8'h00, ctx_q.cppr};

    always_comb begin
        snap.base    = (LINE_ADDR_W'(ctx_q.line_hi) << 32) |
                       (LINE_ADDR_W'(ctx_q.line_lo) << 8);
        snap.os_w0   = ctx_q.os_w0;
        snap.os_w2   = ctx_q.os_w2;
        snap.pool_w2 = ctx_q.pool_w2;
        snap.phys_w0 = {ctx_q.nsr, ctx_q.cppr, ctx_q.phys_lo};
        snap.phys_b  = ctx_q.phys_w2[WORD_W-1 -: 8];
    end
endmodule

// File: rtl/tctx_pull_seq.sv
module tctx_pull_seq
    import tctx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  snap_t                  snap_in,
    output logic                   busy,
    output logic                   wr_valid,
    output logic [LINE_ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0]      wr_data,
    output logic [3:0]             wr_be
);
    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        snap_t             snap;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.active) begin
            if (seq_q.beat == BEAT_W'(NUM_BEATS - 1)) begin
                seq_d.active = 1'b0;
                seq_d.beat   = '0;
            end else begin
                seq_d.beat = seq_q.beat + 1'b1;
            end
        end else if (start) begin
            seq_d.active = 1'b1;
            seq_d.beat   = '0;
            seq_d.snap   = snap_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    logic [7:0] off;
    always_comb begin
        off     = 8'h00;
        wr_data = '0;
        wr_be   = 4'hF;
        case (seq_q.beat)
            BEAT_W'(0): begin off = 8'h10; wr_data = seq_q.snap.os_w0;   end
            BEAT_W'(1): begin off = 8'h18; wr_data = seq_q.snap.os_w2;   end
            BEAT_W'(2): begin off = 8'h28; wr_data = seq_q.snap.pool_w2; end
            BEAT_W'(3): begin off = 8'h30; wr_data = seq_q.snap.phys_w0; end
            default: begin
                off     = 8'h38;
                wr_data = {seq_q.snap.phys_b, 24'h0};
                wr_be   = 4'h8;
            end
        endcase
    end

    assign busy     = seq_q.active;
    assign wr_valid = seq_q.active;
    assign wr_addr  = seq_q.snap.base | LINE_ADDR_W'(ODD_LINE | off);
endmodule

// File: rtl/tctx_presenter.sv
module tctx_presenter
    import tctx_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dlv_valid,
    input  logic [TID_W-1:0]       dlv_thread,
    input  logic [7:0]             dlv_prio,
    input  logic                   req_valid,
    input  logic [2:0]             req_op,
    input  logic [TID_W-1:0]       req_thread,
    input  logic [3:0]             req_word,
    input  logic [31:0]            req_wdata,
    output logic                   rd_valid,
    output logic [31:0]            rd_data,
    output logic                   mem_wr_valid,
    output logic [59:0]            mem_wr_addr,
    output logic [31:0]            mem_wr_data,
    output logic [3:0]             mem_wr_be
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rsp_t;

    op_e               op;
    logic              busy;
    logic              pull_start;
    logic [WORD_W-1:0] rd_all  [NUM_THREADS];
    logic [15:0]       ack_all [NUM_THREADS];
    snap_t             snap_all[NUM_THREADS];
    rsp_t              rsp_d, rsp_q;

    assign op         = op_e'(req_op);
    assign pull_start = req_valid && op == OP_PULL && !busy;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic hit_req;
        logic hit_dlv;
        assign hit_req = req_valid && req_thread == TID_W'(t);
        assign hit_dlv = dlv_valid && dlv_thread == TID_W'(t);
        tctx_thread u_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (hit_req),
            .op       (op),
            .word_idx (req_word),
            .wdata    (req_wdata),
            .pull_go  (pull_start && req_thread == TID_W'(t)),
            .dlv_hit  (hit_dlv),
            .dlv_prio (dlv_prio),
            .rd_word  (rd_all[t]),
            .ack_word (ack_all[t]),
            .snap     (snap_all[t])
        );
    end

    always_comb begin
        rsp_d.valid = req_valid && (op == OP_RD || op == OP_ACK);
        rsp_d.data  = (op == OP_ACK) ? {16'h0, ack_all[req_thread]}
                                     : rd_all[req_thread];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rd_valid = rsp_q.valid;
    assign rd_data  = rsp_q.data;

    tctx_pull_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pull_start),
        .snap_in  (snap_all[req_thread]),
        .busy     (busy),
        .wr_valid (mem_wr_valid),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data),
        .wr_be    (mem_wr_be)
    );
endmodule

// File: rtl/tctx_presenter_chk.sv
module tctx_presenter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_op,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        mem_wr_valid,
    input logic [59:0] mem_wr_addr,
    input logic [3:0]  mem_wr_be
);
    logic [2:0] run_q;
    logic       rd_req;

    assign rd_req = req_valid && (req_op == 3'd0 || req_op == 3'd2);

    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (mem_wr_valid) run_q <= run_q + 3'd1;
        else                   run_q <= '0;
    end

    assert_rd_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_no_spurious_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    assert_ack_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_op == 3'd2) && rd_valid) |-> rd_data[31:16] == 16'h0);
    assert_stream_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> run_q < 3'd5);
    assert_stream_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(req_valid && req_op == 3'd4));
    assert_byte_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_addr[6:0] == 7'h38) |-> mem_wr_be == 4'h8);
    assert_odd_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_addr[7]);
    assert_same_area_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && $past(mem_wr_valid)) |-> mem_wr_addr[59:8] == $past(mem_wr_addr[59:8]));
endmodule

bind tctx_presenter tctx_presenter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_be    (mem_wr_be)
);

// File: tb/tctx_presenter_tb.sv
module tctx_presenter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dlv_valid = 1'b0;
    logic [1:0]  dlv_thread = '0;
    logic [7:0]  dlv_prio = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_thread = '0;
    logic [3:0]  req_word = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        mem_wr_valid;
    logic [59:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tctx_presenter u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] o, input logic [1:0] t,
                         input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = o; req_thread = t; req_word = w; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic deliver(input logic [1:0] t, input logic [7:0] p);
        @(negedge clk);
        dlv_valid = 1'b1; dlv_thread = t; dlv_prio = p;
        @(negedge clk);
        dlv_valid = 1'b0;
    endtask

    task automatic both(input logic [2:0] o, input logic [1:0] t,
                        input logic [31:0] d, input logic [7:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_op = o; req_thread = t; req_word = 4'd12; req_wdata = d;
        dlv_valid = 1'b1; dlv_thread = t; dlv_prio = p;
        @(negedge clk);
        req_valid = 1'b0; dlv_valid = 1'b0;
    endtask

    task automatic beat(input string tag, input logic [59:0] a,
                        input logic [31:0] d, input logic [3:0] be);
        chk({tag, " valid"}, 64'(mem_wr_valid), 64'd1);
        chk({tag, " addr"}, 64'(mem_wr_addr), 64'(a));
        chk({tag, " data"}, 64'(mem_wr_data), 64'(d));
        chk({tag, " be"}, 64'(mem_wr_be), 64'(be));
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [59:0] base;
        logic [7:0]  cl [6];
        cl[0] = 8'h00; cl[1] = 8'h01; cl[2] = 8'h05;
        cl[3] = 8'h80; cl[4] = 8'hFE; cl[5] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        for (int t = 0; t < 4; t++) begin
            do_op(3'd0, 2'(t), 4'd12, 0);
            chk("R1 phys w0", 64'(rd_data), 64'h00FF0000);
            do_op(3'd0, 2'(t), 4'd6, 0);
            chk("R1 os w2", 64'(rd_data), 64'h0);
        end
        // R2 word access
        for (int t = 0; t < 4; t++) begin
            do_op(3'd1, 2'(t), 4'd12, 32'hAAAA1230 + 32'(t));
            do_op(3'd0, 2'(t), 4'd12, 0);
            chk("R2 phys w0 low half", 64'(rd_data), 64'(32'h00FF1230 + 32'(t)));
            chk("R2 rd_valid", 64'(rd_valid), 64'd1);
        end
        do_op(3'd1, 2'd0, 4'd8, 32'hDEADBEEF);
        do_op(3'd0, 2'd0, 4'd8, 0);
        chk("R2 unmapped", 64'(rd_data), 64'h0);
        do_op(3'd1, 2'd0, 4'd4, 32'h0BADF00D);
        @(negedge clk);
        chk("R2 no rd on write", 64'(rd_valid), 64'd0);
        do_op(3'd0, 2'd1, 4'd4, 0);
        chk("R2 thread isolation", 64'(rd_data), 64'h0);
        // R3 R4 R5 sweep of priority against current priority
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c < 6; c++) begin
                for (int p = 0; p < 256; p++) begin
                    logic [7:0] cv;
                    cv = cl[c];
                    do_op(3'd3, 2'(t), 4'd0, 32'(cv));
                    deliver(2'(t), 8'(p));
                    do_op(3'd0, 2'(t), 4'd12, 0);
                    if (p < int'(cv)) begin
                        chk("R3 presented", 64'(rd_data), 64'({8'h80, cv, 16'h1230 + 16'(t)}));
                        do_op(3'd2, 2'(t), 4'd0, 0);
                        chk("R4 ack", 64'(rd_data), 64'({16'h0, 8'h80, 8'(p)}));
                    end else begin
                        chk("R3 ignored", 64'(rd_data), 64'({8'h00, cv, 16'h1230 + 16'(t)}));
                        do_op(3'd2, 2'(t), 4'd0, 0);
                        chk("R5 idle ack", 64'(rd_data), 64'({24'h0, cv}));
                    end
                    do_op(3'd3, 2'(t), 4'd0, 32'hFF);
                end
            end
        end
        do_op(3'd2, 2'd0, 4'd0, 0);
        do_op(3'd0, 2'd0, 4'd12, 0);
        chk("R5 unchanged after idle ack", 64'(rd_data), 64'h00FF1230);
        // R3 pending choice
        deliver(2'd0, 8'd9); deliver(2'd0, 8'd4);
        do_op(3'd2, 2'd0, 4'd0, 0);
        chk("R3 better replaces", 64'(rd_data), 64'h8004);
        do_op(3'd3, 2'd0, 4'd0, 32'hFF);
        deliver(2'd0, 8'd4); deliver(2'd0, 8'd9);
        do_op(3'd2, 2'd0, 4'd0, 0);
        chk("R3 worse ignored", 64'(rd_data), 64'h8004);
        do_op(3'd3, 2'd0, 4'd0, 32'hFF);
        do_op(3'd0, 2'd0, 4'd12, 0);
        chk("R4 status cleared", 64'(rd_data), 64'h00FF1230);
        // R6 current-priority write
        deliver(2'd0, 8'd6);
        do_op(3'd3, 2'd0, 4'd0, 32'h10);
        do_op(3'd0, 2'd0, 4'd12, 0);
        chk("R6 kept", 64'(rd_data), 64'h80101230);
        do_op(3'd3, 2'd0, 4'd0, 32'h06);
        do_op(3'd0, 2'd0, 4'd12, 0);
        chk("R6 dropped", 64'(rd_data), 64'h00061230);
        do_op(3'd3, 2'd0, 4'd0, 32'hFF);
        // R11 same-cycle conflicts on thread 1
        deliver(2'd1, 8'd5);
        both(3'd2, 2'd1, 0, 8'd3);
        chk("R11 ack in conflict", 64'(rd_data), 64'h8005);
        do_op(3'd0, 2'd1, 4'd12, 0);
        chk("R11 new delivery kept", 64'(rd_data), 64'h80051231);
        do_op(3'd2, 2'd1, 4'd0, 0);
        chk("R11 second ack", 64'(rd_data), 64'h8003);
        do_op(3'd3, 2'd1, 4'd0, 32'hFF);
        both(3'd3, 2'd1, 32'h02, 8'd3);
        do_op(3'd0, 2'd1, 4'd12, 0);
        chk("R11 judged after write", 64'(rd_data), 64'h00021231);
        do_op(3'd3, 2'd1, 4'd0, 32'hFF);
        // R7 R8 R9 R10 pull on thread 2
        do_op(3'd1, 2'd2, 4'd1, 32'hFABCDEF1);
        do_op(3'd1, 2'd2, 4'd2, 32'hFF123456);
        do_op(3'd0, 2'd2, 4'd1, 0);
        chk("R8 upper field", 64'(rd_data), 64'h0ABCDEF1);
        do_op(3'd1, 2'd2, 4'd4, 32'h11223344);
        do_op(3'd1, 2'd2, 4'd6, 32'h80000A01);
        do_op(3'd1, 2'd2, 4'd10, 32'h80000B02);
        do_op(3'd1, 2'd2, 4'd14, 32'hC5000000);
        do_op(3'd1, 2'd3, 4'd6, 32'h80000077);
        base = 60'hABCDEF112345600;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4; req_thread = 2'd2;
        @(negedge clk);
        req_thread = 2'd3;
        beat("R7 beat0", base | 60'h90, 32'h11223344, 4'hF);
        @(negedge clk);
        req_valid = 1'b0;
        beat("R7 beat1", base | 60'h98, 32'h80000A01, 4'hF);
        @(negedge clk);
        beat("R7 beat2", base | 60'hA8, 32'h80000B02, 4'hF);
        @(negedge clk);
        beat("R7 beat3", base | 60'hB0, 32'h00FF1232, 4'hF);
        @(negedge clk);
        beat("R7 beat4 R8", base | 60'hB8, 32'hC5000000, 4'h8);
        @(negedge clk);
        chk("R10 no second stream", 64'(mem_wr_valid), 64'd0);
        do_op(3'd0, 2'd3, 4'd6, 0);
        chk("R10 other thread kept", 64'(rd_data), 64'h80000077);
        do_op(3'd0, 2'd2, 4'd6, 0);
        chk("R9 os w2", 64'(rd_data), 64'h00000A01);
        do_op(3'd0, 2'd2, 4'd10, 0);
        chk("R9 pool w2", 64'(rd_data), 64'h00000B02);
        do_op(3'd0, 2'd2, 4'd14, 0);
        chk("R9 phys w2", 64'(rd_data), 64'h45000000);
        do_op(3'd0, 2'd2, 4'd4, 0);
        chk("R9 os w0 kept", 64'(rd_data), 64'h11223344);
        // R7 a pull on thread 0 with a zero base
        do_op(3'd4, 2'd0, 4'd0, 0);
        beat("R8 zero base", 60'h90, 32'h0BADF00D, 4'hF);
        repeat (6) @(negedge clk);
        chk("R7 stream ended", 64'(mem_wr_valid), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule